// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Sequencer

This block sits between a simple register-style host port and an 8-bit asynchronous NAND flash bus. Software selects a device through a chip-enable field, releases write protect, and programs a single timing word. Each single-byte access to a per-device window then becomes one flash bus cycle: a command latch, an address latch, a data write or a data read. Each cycle has three programmable phases. In the first, the latch enables and write data settle. In the second, the WE# or RE# strobe is held low. In the third, everything is held before the bus goes idle.

The host issues one request per cycle while `hst_ready` is high. A bus access pulls `hst_ready` low until its final phase has ended, so only one flash cycle is ever in flight. Register accesses complete at once. Read data is returned on `hst_rdata` and stays there until the next read.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset `hst_ready` is 1, every CE# is high, WP# is low, WE# and RE# are high, CLE, ALE and `nand_dq_oe` are 0, `hst_rdata` is 0, and the timing register at address 0x004 reads 0x1081.
- R2: The control register at address 0x000 holds a chip-enable field in bits 7:0. CE#[n] is driven low exactly when bit n is 1, writing 0 raises every CE#, and the field reads back in bits 7:0.
- R3: Control bit 8 drives WP# directly (1 gives WP# high). Bit 9 is read-only and returns the level of R/B# after a two-flop synchronizer. Other control bits read 0.
- R4: The timing register holds the setup length in bits 17:12, the strobe length in bits 10:5 and the hold length in bits 4:0. All other bits read 0.
- R5: Window addresses have bit 11 set, with the bank number in bits 10:8. A write to window offset 0x08 runs one cycle with CLE high, ALE low and exactly one WE# low pulse.
- R6: A write to window offset 0x04 runs one cycle with ALE high, CLE low and exactly one WE# low pulse.
- R7: A write to window offset 0x00 runs one cycle with CLE and ALE low and exactly one WE# pulse. `nand_dq_oe` is 1 with the written byte on `nand_dq_o` for the whole cycle.
- R8: A read from window offset 0x00 produces exactly one RE# low pulse, keeps `nand_dq_oe` 0 and never lowers WE#. It samples DQ on the last strobe clock and returns the byte in `hst_rdata[7:0]`, with the upper bits 0, by the time `hst_ready` returns.
- R9: A bus cycle holds the latch enables for s clocks before the strobe falls, keeps the strobe low for p clocks, then holds for h clocks. `hst_ready` is low for exactly s+p+h clocks.
- R10: A timing field of 0 is used as 1 clock.
- R11: Requests made while `hst_ready` is low are dropped: they neither change a register nor start a cycle.
- R12: An access to a window whose bank bit is clear in the chip-enable field still runs on the bus with CE# as programmed. A read through such a window returns 0xFF.
- R13: Window offsets other than 0x00, 0x04 and 0x08, reads of the command and address ports, and unassigned register addresses start no bus cycle. Reads of these return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 12 | Host byte address |
| hst_wr | input | 1 | Host write request, taken while ready is high |
| hst_rd | input | 1 | Host read request, taken while ready is high and write is low |
| hst_wdata | input | 32 | Host write data (byte ports use bits 7:0) |
| hst_rdata | output | 32 | Result of the last read |
| hst_ready | output | 1 | High when a new request can be taken |
| nand_ce_n | output | 8 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_o | output | 8 | DQ output byte |
| nand_dq_oe | output | 1 | DQ output enable |
| nand_dq_i | input | 8 | DQ input byte |
| nand_rb_n | input | 1 | Ready/busy from the flash, low when busy |

## Verification
All four cycle kinds run with the reset timing word. For each, the bench records the latch-enable levels, the strobe pulse count and the DQ drive, which separates command, address, data-write and data-read decoding. The same command cycle then runs under an asymmetric timing word (3/2/4) and under an all-zero word. The first shows whether each field reaches its own phase; the second shows whether zero is stretched to one clock. Further runs cover a request injected mid-cycle, a read through a bank that is not enabled, and accesses to unassigned offsets. These show whether busy-time requests are dropped, whether the 0xFF fallback applies, and whether stray addresses start cycles.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int SETUP_W = 6;
    localparam int WIDTH_W = 6;
    localparam int HOLD_W  = 5;
    localparam int CNT_W   = 6;

    typedef enum logic [1:0] {
        OP_CMD = 2'd0,
        OP_ADR = 2'd1,
        OP_DWR = 2'd2,
        OP_DRD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [WIDTH_W-1:0] width;
        logic [HOLD_W-1:0]  hold;
    } tim_t;

    function automatic tim_t tim_from_word(input logic [31:0] w);
        tim_t t;
        t.setup = w[17:12];
        t.width = w[10:5];
        t.hold  = w[4:0];
        return t;
    endfunction

    function automatic logic [31:0] tim_to_word(input tim_t t);
        return {14'd0, t.setup, 1'b0, t.width, t.hold};
    endfunction

    // phase length minus one, with zero stretched to one clock
    function automatic logic [CNT_W-1:0] phase_load(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

endpackage

// File: rtl/nseq_host_regs.sv
module nseq_host_regs
    import nseq_pkg::*;
#(
    parameter int          CS_N        = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] TIM_RST     = 32'h0000_1081,
    localparam int         BANK_W      = $clog2(CS_N),
    localparam int         ADDR_W      = 9 + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [31:0]       wdata,
    input  logic              idle,
    input  logic              rb_n,
    input  logic              rd_done,
    input  logic [7:0]        rd_byte,
    output logic [CS_N-1:0]   ce_sel,
    output logic              wp_rel,
    output tim_t              tim,
    output logic              start,
    output op_e               start_op,
    output logic [7:0]        start_byte,
    output logic              start_hit,
    output logic [31:0]       rdata
);

    logic              win;
    logic [BANK_W-1:0] bank;
    logic [7:0]        off;
    logic              is_ctl, is_tim;
    logic              w_cmd, w_adr, w_dat;
    logic              wr_ok, rd_ok;
    logic              rb_s;
    logic [31:0]       reg_view;
    logic              unused_wd;

    assign win   = addr[ADDR_W-1];
    assign bank  = addr[8 +: BANK_W];
    assign off   = addr[7:0];
    assign is_ctl = (addr == ADDR_W'(0));
    assign is_tim = (addr == ADDR_W'(4));
    assign w_cmd = win && (off == 8'h08);
    assign w_adr = win && (off == 8'h04);
    assign w_dat = win && (off == 8'h00);

    assign wr_ok = idle && wr;
    assign rd_ok = idle && rd && !wr;

    assign unused_wd = ^{wdata[31:18], wdata[11]};

    // R/B# synchronizer
    generate
        if (SYNC_STAGES <= 1) begin : g_sync1
            logic rb_q;
            always_ff @(posedge clk) begin
                if (rst) rb_q <= 1'b1;
                else     rb_q <= rb_n;
            end
            assign rb_s = rb_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] rb_pipe;
            always_ff @(posedge clk) begin
                if (rst) rb_pipe <= '1;
                else     rb_pipe <= {rb_pipe[SYNC_STAGES-2:0], rb_n};
            end
            assign rb_s = rb_pipe[SYNC_STAGES-1];
        end
    endgenerate

    // bus cycle launch
    always_comb begin
        start      = (wr_ok && (w_cmd || w_adr || w_dat)) || (rd_ok && w_dat);
        start_byte = wdata[7:0];
        start_hit  = ce_sel[bank];
        if (!wr)        start_op = OP_DRD;
        else if (w_cmd) start_op = OP_CMD;
        else if (w_adr) start_op = OP_ADR;
        else            start_op = OP_DWR;
    end

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_sel <= '0;
            wp_rel <= 1'b0;
            tim    <= tim_from_word(TIM_RST);
        end else if (wr_ok) begin
            if (is_ctl) begin
                ce_sel <= wdata[CS_N-1:0];
                wp_rel <= wdata[8];
            end
            if (is_tim) tim <= tim_from_word(wdata);
        end
    end

    always_comb begin
        reg_view = '0;
        if (is_ctl) begin
            reg_view[CS_N-1:0] = ce_sel;
            reg_view[8]        = wp_rel;
            reg_view[9]        = rb_s;
        end else if (is_tim) begin
            reg_view = tim_to_word(tim);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  rdata <= '0;
        else if (rd_done)         rdata <= {24'd0, rd_byte};
        else if (rd_ok && !start) rdata <= reg_view;
    end

endmodule

// File: rtl/nseq_phase_seq.sv
module nseq_phase_seq
    import nseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  op_e        start_op,
    input  logic [7:0] start_byte,
    input  logic       start_hit,
    input  tim_t       tim,
    input  logic [7:0] dq_i,
    output phase_e     phase,
    output op_e        op,
    output logic [7:0] byte_q,
    output logic       rd_done,
    output logic [7:0] rd_byte
);

    logic [CNT_W-1:0] cnt;
    logic             hit_q;
    logic             last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            op      <= OP_CMD;
            byte_q  <= '0;
            hit_q   <= 1'b0;
            cnt     <= '0;
            rd_done <= 1'b0;
            rd_byte <= '0;
        end else begin
            rd_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_SETUP;
                        op     <= start_op;
                        byte_q <= start_byte;
                        hit_q  <= start_hit;
                        cnt    <= phase_load(CNT_W'(tim.setup));
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_STROBE;
                        cnt   <= phase_load(CNT_W'(tim.width));
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= phase_load(CNT_W'(tim.hold));
                        if (op == OP_DRD) begin
                            rd_done <= 1'b1;
                            rd_byte <= hit_q ? dq_i : 8'hFF;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) phase <= PH_IDLE;
                    else      cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nseq_pin_drv.sv
module nseq_pin_drv
    import nseq_pkg::*;
#(
    parameter int CS_N = 8
) (
    input  phase_e          phase,
    input  op_e             op,
    input  logic [7:0]      byte_q,
    input  logic [CS_N-1:0] ce_sel,
    input  logic            wp_rel,
    output logic [CS_N-1:0] ce_n,
    output logic            cle,
    output logic            ale,
    output logic            we_n,
    output logic            re_n,
    output logic            wp_n,
    output logic [7:0]      dq_o,
    output logic            dq_oe
);

    logic busy, strobe;

    assign busy   = (phase != PH_IDLE);
    assign strobe = (phase == PH_STROBE);

    generate
        for (genvar g = 0; g < CS_N; g++) begin : g_ce
            assign ce_n[g] = ~ce_sel[g];
        end
    endgenerate

    always_comb begin
        cle   = busy && (op == OP_CMD);
        ale   = busy && (op == OP_ADR);
        we_n  = !(strobe && (op != OP_DRD));
        re_n  = !(strobe && (op == OP_DRD));
        dq_oe = busy && (op != OP_DRD);
        dq_o  = dq_oe ? byte_q : 8'h00;
        wp_n  = wp_rel;
    end

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nseq_pkg::*;
#(
    parameter int          CS_N        = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] TIM_RST     = 32'h0000_1081,
    localparam int         BANK_W      = $clog2(CS_N),
    localparam int         ADDR_W      = 9 + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    output logic              hst_ready,
    output logic [CS_N-1:0]   nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb_n
);

    logic [CS_N-1:0] ce_sel;
    logic            wp_rel;
    tim_t            tim;
    logic            start, start_hit, rd_done;
    op_e             start_op, op;
    logic [7:0]      start_byte, byte_q, rd_byte;
    phase_e          phase;

    assign hst_ready = (phase == PH_IDLE);

    nseq_host_regs #(
        .CS_N(CS_N), .SYNC_STAGES(SYNC_STAGES), .TIM_RST(TIM_RST)
    ) regs_i (
        .clk(clk), .rst(rst), .addr(hst_addr), .wr(hst_wr), .rd(hst_rd),
        .wdata(hst_wdata), .idle(hst_ready), .rb_n(nand_rb_n),
        .rd_done(rd_done), .rd_byte(rd_byte), .ce_sel(ce_sel),
        .wp_rel(wp_rel), .tim(tim), .start(start), .start_op(start_op),
        .start_byte(start_byte), .start_hit(start_hit), .rdata(hst_rdata)
    );

    nseq_phase_seq seq_i (
        .clk(clk), .rst(rst), .start(start), .start_op(start_op),
        .start_byte(start_byte), .start_hit(start_hit), .tim(tim),
        .dq_i(nand_dq_i), .phase(phase), .op(op), .byte_q(byte_q),
        .rd_done(rd_done), .rd_byte(rd_byte)
    );

    nseq_pin_drv #(.CS_N(CS_N)) pins_i (
        .phase(phase), .op(op), .byte_q(byte_q), .ce_sel(ce_sel),
        .wp_rel(wp_rel), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .wp_n(nand_wp_n),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

endmodule

// File: rtl/nseq_chk.sv
module nseq_chk #(
    parameter int CS_N = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            hst_ready,
    input logic [CS_N-1:0] nand_ce_n,
    input logic            nand_cle,
    input logic            nand_ale,
    input logic            nand_we_n,
    input logic            nand_re_n,
    input logic            nand_wp_n,
    input logic            nand_dq_oe
);

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R7
    oe_vs_read_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_dq_oe && !nand_re_n));

    // R5
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R9
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !hst_ready);

    // R9
    hold_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(nand_we_n) || $rose(nand_re_n)) |-> !hst_ready);

    // R11
    ce_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!hst_ready && $past(!hst_ready)) |-> ($stable(nand_ce_n) && $stable(nand_wp_n)));

endmodule

bind nand_cycle_seq nseq_chk #(.CS_N(CS_N)) chk_i (
    .clk(clk), .rst(rst), .hst_ready(hst_ready), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n), .nand_dq_oe(nand_dq_oe)
);

// File: tb/nand_cycle_seq_tb_top.sv
module nand_cycle_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] hst_addr = '0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_ready;
    logic [7:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_i = 8'h00;
    logic        nand_rb_n = 1'b1;

    int n_chk = 0;
    int n_err = 0;

    int s_busy, s_we_lo, s_re_lo, s_we_fall, s_re_fall, s_first_lo;
    int s_cle, s_ale, s_oe, s_dq_bad, s_ce_bad;
    logic [31:0] s_rdata;

    always #5 clk = ~clk;

    nand_cycle_seq dut_i (
        .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wr(hst_wr),
        .hst_rd(hst_rd), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_ready(hst_ready), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_wp_n(nand_wp_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        @(negedge clk);
        hst_rd = 1'b0;
        d = hst_rdata;
    endtask

    // runs one access and records pin activity sample by sample
    task automatic bus_op(input logic [11:0] a, input logic [7:0] d, input bit rd,
                          input bit intrude, input logic [7:0] exp_ce_n);
        logic pw, pr;
        s_busy = 0; s_we_lo = 0; s_re_lo = 0; s_we_fall = 0; s_re_fall = 0;
        s_first_lo = -1; s_cle = 0; s_ale = 0; s_oe = 0; s_dq_bad = 0; s_ce_bad = 0;
        pw = 1'b1; pr = 1'b1;
        @(negedge clk);
        hst_addr = a; hst_wdata = {24'd0, d}; hst_wr = !rd; hst_rd = rd;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (i == 0) begin hst_wr = 1'b0; hst_rd = 1'b0; end
            if (hst_ready) begin
                s_rdata = hst_rdata;
                break;
            end
            s_busy++;
            if (!nand_we_n) s_we_lo++;
            if (!nand_re_n) s_re_lo++;
            if (pw && !nand_we_n) s_we_fall++;
            if (pr && !nand_re_n) s_re_fall++;
            if ((!nand_we_n || !nand_re_n) && s_first_lo < 0) s_first_lo = i;
            if (nand_cle) s_cle++;
            if (nand_ale) s_ale++;
            if (nand_dq_oe) s_oe++;
            if (nand_dq_oe && nand_dq_o !== d) s_dq_bad++;
            if (nand_ce_n !== exp_ce_n) s_ce_bad++;
            pw = nand_we_n; pr = nand_re_n;
            if (intrude && i == 1) begin hst_addr = 12'h004; hst_wdata = 32'h0; hst_wr = 1'b1; end
            if (intrude && i == 2) hst_wr = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 ready", hst_ready, 1);
        chk("R1 ce_n", nand_ce_n, 8'hFF);
        chk("R1 wp_n", nand_wp_n, 0);
        chk("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
        chk("R1 latches/oe", {nand_cle, nand_ale, nand_dq_oe}, 3'b000);
        chk("R1 rdata", hst_rdata, 0);
        reg_rd(12'h004, v);
        chk("R1 timing reset", v, 32'h1081);
    endtask

    task automatic t_control();
        logic [31:0] v;
        reg_wr(12'h000, 32'h104);
        chk("R2 ce_n bank2", nand_ce_n, 8'hFB);
        chk("R3 wp_n released", nand_wp_n, 1);
        reg_rd(12'h000, v);
        chk("R2 R3 control readback", v, 32'h304);
        nand_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        reg_rd(12'h000, v);
        chk("R3 busy flag", v, 32'h104);
        nand_rb_n = 1'b1;
        repeat (4) @(negedge clk);
        reg_wr(12'h000, 32'h0);
        chk("R2 deselect all", nand_ce_n, 8'hFF);
        chk("R3 wp_n protect", nand_wp_n, 0);
        reg_wr(12'h000, 32'h104);
    endtask

    task automatic t_cmd();
        bus_op(12'hA08, 8'h70, 0, 0, 8'hFB);
        chk("R5 busy clocks", s_busy, 6);
        chk("R5 one WE pulse", s_we_fall, 1);
        chk("R5 CLE whole cycle", s_cle, 6);
        chk("R5 ALE low", s_ale, 0);
        chk("R9 setup clocks", s_first_lo, 1);
        chk("R9 strobe clocks", s_we_lo, 4);
        chk("R5 no RE", s_re_lo, 0);
    endtask

    task automatic t_addr();
        bus_op(12'hA04, 8'h12, 0, 0, 8'hFB);
        chk("R6 ALE whole cycle", s_ale, 6);
        chk("R6 CLE low", s_cle, 0);
        chk("R6 one WE pulse", s_we_fall, 1);
    endtask

    task automatic t_dwr();
        bus_op(12'hA00, 8'h5A, 0, 0, 8'hFB);
        chk("R7 latches low", s_cle + s_ale, 0);
        chk("R7 oe whole cycle", s_oe, 6);
        chk("R7 dq byte", s_dq_bad, 0);
        chk("R7 one WE pulse", s_we_fall, 1);
    endtask

    task automatic t_drd();
        nand_dq_i = 8'hC3;
        bus_op(12'hA00, 8'h00, 1, 0, 8'hFB);
        chk("R8 one RE pulse", s_re_fall, 1);
        chk("R8 RE width", s_re_lo, 4);
        chk("R8 no WE", s_we_lo, 0);
        chk("R8 oe off", s_oe, 0);
        chk("R8 read data", s_rdata, 32'hC3);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        reg_wr(12'h004, 32'hFFFF_FFFF);
        reg_rd(12'h004, v);
        chk("R4 field mask", v, 32'h3F7FF);
        reg_wr(12'h004, 32'h3044);
        reg_rd(12'h004, v);
        chk("R4 readback", v, 32'h3044);
        bus_op(12'hA08, 8'h90, 0, 0, 8'hFB);
        chk("R9 busy s+p+h", s_busy, 9);
        chk("R9 setup 3", s_first_lo, 3);
        chk("R9 strobe 2", s_we_lo, 2);
    endtask

    task automatic t_zero();
        reg_wr(12'h004, 32'h0);
        bus_op(12'hA08, 8'hFF, 0, 0, 8'hFB);
        chk("R10 busy 3", s_busy, 3);
        chk("R10 setup 1", s_first_lo, 1);
        chk("R10 strobe 1", s_we_lo, 1);
        reg_wr(12'h004, 32'h1081);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        bus_op(12'hA08, 8'h60, 0, 1, 8'hFB);
        chk("R11 single cycle", s_we_fall, 1);
        chk("R11 busy unchanged", s_busy, 6);
        repeat (3) @(negedge clk);
        chk("R11 no extra cycle", hst_ready, 1);
        reg_rd(12'h004, v);
        chk("R11 timing kept", v, 32'h1081);
    endtask

    task automatic t_nosel();
        reg_wr(12'h000, 32'h100);
        nand_dq_i = 8'h3C;
        bus_op(12'h800, 8'h00, 1, 0, 8'hFF);
        chk("R12 read ff", s_rdata, 32'hFF);
        chk("R12 cycle runs", s_re_fall, 1);
        chk("R12 ce_n high", s_ce_bad, 0);
        reg_wr(12'h000, 32'h102);
        bus_op(12'h800, 8'h00, 1, 0, 8'hFD);
        chk("R12 other bank ff", s_rdata, 32'hFF);
        chk("R12 ce_n kept", s_ce_bad, 0);
        bus_op(12'h900, 8'h00, 1, 0, 8'hFD);
        chk("R12 enabled bank data", s_rdata, 32'h3C);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        int lo;
        lo = 0;
        @(negedge clk);
        hst_addr = 12'h80C; hst_wdata = 32'hAA; hst_wr = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            hst_wr = 1'b0;
            if (!hst_ready || !nand_we_n) lo++;
        end
        chk("R13 stray offset no cycle", lo, 0);
        reg_rd(12'h010, v);
        chk("R13 unassigned reads 0", v, 0);
        reg_rd(12'h908, v);
        chk("R13 cmd port read 0", v, 0);
        chk("R13 cmd port read no RE", {hst_ready, nand_re_n}, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_control();
        t_cmd();
        t_addr();
        t_dwr();
        t_drd();
        t_timing();
        t_zero();
        t_ignore();
        t_nosel();
        t_unmapped();
        summary();
    end

endmodule